// File: doc/BRIEF.md
# Display FIFO Threshold DMA Requester

This block sits beside the three output FIFOs of a video display path: one for luma, one for blue-difference chroma and one for red-difference chroma. It compares the free space that each FIFO reports, counted in double words, against a programmed burst threshold. When a FIFO has room for another burst, the block raises a one-cycle DMA request for that FIFO. After that it holds the FIFO quiet until the DMA engine acknowledges the transfer. The control register word is taken as an input. Two 10-bit thresholds live in it, and the field indicator picks which one is active, so each field can use its own burst size.

In component video mode each chroma FIFO uses half of the active threshold, rounded up to a whole double word. In raw mode only the first FIFO is used. It compares against the full threshold, and the two chroma requesters stay silent. Raw mode also runs a frame pixel counter. A 4-bit divisor field sets how many output clock ticks make up one pixel. A frame-start pulse clears the counter and its prescaler.

Top module: `disp_fifo_dma_req`

## Requirements
- R1: `req_y` pulses high for one cycle in the cycle after an edge at which `free_y` is greater than or equal to the active threshold, the threshold is nonzero and no luma request is pending.
- R2: In component mode (`raw_mode`=0), `req_cb`/`req_cr` behave like R1 against `free_cb`/`free_cr`, using the chroma threshold (T + (T mod 2)) / 2, where T is the active threshold.
- R3: The active threshold T is `ctrl_word[9:0]` when `field2`=0, and `ctrl_word[25:16]` when `field2`=1.
- R4: In raw mode (`raw_mode`=1), `req_y` compares against the full T, and `req_cb`/`req_cr` stay low.
- R5: Once a FIFO has issued a request, it issues no further request until its `ack_*` input is sampled high at a clock edge. From the following edge onward it may request again.
- R6: When the active threshold is 0, no FIFO requests.
- R7: In raw mode, `pix_count` increments once every N `pix_tick` pulses, where N is `ctrl_word[15:12]` and the value 0 stands for 16. In component mode neither `pix_count` nor its prescaler moves.
- R8: A `frame_start` sampled high clears `pix_count` and the prescaler at that edge. This takes priority over a tick.
- R9: Bits 31:26 and 11:10 of `ctrl_word` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Threshold/divisor control register contents |
| field2 | input | 1 | High while field 2 is being output |
| raw_mode | input | 1 | 1 = raw data mode, 0 = component video mode |
| free_y | input | FREE_W | Free space of luma (or raw) FIFO in double words |
| free_cb | input | FREE_W | Free space of blue-difference chroma FIFO |
| free_cr | input | FREE_W | Free space of red-difference chroma FIFO |
| ack_y | input | 1 | DMA acknowledge for luma FIFO |
| ack_cb | input | 1 | DMA acknowledge for blue-difference FIFO |
| ack_cr | input | 1 | DMA acknowledge for red-difference FIFO |
| frame_start | input | 1 | Start-of-frame pulse |
| pix_tick | input | 1 | Output clock enable, one per output value |
| req_y | output | 1 | DMA request pulse, luma FIFO |
| req_cb | output | 1 | DMA request pulse, blue-difference FIFO |
| req_cr | output | 1 | DMA request pulse, red-difference FIFO |
| pix_count | output | PIX_W | Frame pixel counter |

## Verification
The assertions assume that the control word, the mode and the field indicator are ordinary synchronous inputs that may change at any edge. They also assume that an acknowledge can arrive at any time, including while no request is pending. The pixel counter check further assumes that the counter never wraps within a frame. The random stimulus keeps to these assumptions: it holds the mode and the divisor steady for runs of cycles, and it issues frame-start pulses often enough that the 24-bit count stays far from its limit.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int THR_W = 10;
  localparam int DIV_W = 4;
  localparam int PRE_W = DIV_W + 1;

  // Half of a threshold, rounded up to the next whole double word.
  function automatic logic [THR_W-1:0] chroma_thr(input logic [THR_W-1:0] t);
    logic [THR_W:0] s;
    s = {1'b0, t} + {{THR_W{1'b0}}, t[0]};
    return s[THR_W:1];
  endfunction

  // Divisor field to tick count; the zero code stands for 2**DIV_W.
  function automatic logic [PRE_W-1:0] div_eff(input logic [DIV_W-1:0] d);
    return (d == '0) ? PRE_W'(1 << DIV_W) : {1'b0, d};
  endfunction
endpackage

// File: rtl/dreq_chan.sv
module dreq_chan
  import dreq_pkg::*;
#(
  parameter int FREE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [THR_W-1:0]  thr,
  input  logic [FREE_W-1:0] free,
  input  logic              ack,
  output logic              req
);
  localparam int CMP_W = (FREE_W > THR_W) ? FREE_W : THR_W;

  logic pend;
  logic room_hit;
  logic fire;

  assign room_hit = en && (thr != '0) && (CMP_W'(free) >= CMP_W'(thr));
  assign fire     = room_hit && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      req  <= 1'b0;
    end else if (fire) begin
      pend <= 1'b1;
      req  <= 1'b1;
    end else begin
      req <= 1'b0;
      if (ack) pend <= 1'b0;
    end
  end

  // R1
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R5
  no_req_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> !req);
  // R6
  zero_thr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |=> !req);
  // R4
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !req);
endmodule

// File: rtl/dreq_pixdiv.sv
module dreq_pixdiv
  import dreq_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             frame_start,
  input  logic [DIV_W-1:0] div,
  output logic [PIX_W-1:0] pix
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;
  logic             adv;
  logic             wrap;

  assign limit = div_eff(div);
  assign adv   = run && tick;
  assign wrap  = adv && (pre_cnt >= limit - PRE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pix     <= '0;
    end else if (frame_start) begin
      pre_cnt <= '0;
      pix     <= '0;
    end else if (wrap) begin
      pre_cnt <= '0;
      pix     <= pix + PIX_W'(1);
    end else if (adv) begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  // R8
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pix == '0));
  // R7
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (pix == $past(pix)) || (pix == $past(pix) + PIX_W'(1)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !frame_start) |=> $stable(pix));
endmodule

// File: rtl/disp_fifo_dma_req.sv
module disp_fifo_dma_req
  import dreq_pkg::*;
#(
  parameter int FREE_W = 11,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl_word,
  input  logic              field2,
  input  logic              raw_mode,
  input  logic [FREE_W-1:0] free_y,
  input  logic [FREE_W-1:0] free_cb,
  input  logic [FREE_W-1:0] free_cr,
  input  logic              ack_y,
  input  logic              ack_cb,
  input  logic              ack_cr,
  input  logic              frame_start,
  input  logic              pix_tick,
  output logic              req_y,
  output logic              req_cb,
  output logic              req_cr,
  output logic [PIX_W-1:0]  pix_count
);
  localparam int NCH = 3;

  // Control word fields; other bits are left unread.
  logic [THR_W-1:0] thr_f1;
  logic [THR_W-1:0] thr_f2;
  logic [DIV_W-1:0] div_fld;
  logic [THR_W-1:0] thr_act;
  logic [THR_W-1:0] thr_half;

  assign thr_f1   = ctrl_word[9:0];
  assign thr_f2   = ctrl_word[25:16];
  assign div_fld  = ctrl_word[15:12];
  assign thr_act  = field2 ? thr_f2 : thr_f1;
  assign thr_half = chroma_thr(thr_act);

  logic [NCH-1:0]             ch_en;
  logic [NCH-1:0][THR_W-1:0]  ch_thr;
  logic [NCH-1:0][FREE_W-1:0] ch_free;
  logic [NCH-1:0]             ch_ack;
  logic [NCH-1:0]             ch_req;

  assign ch_free = {free_cr, free_cb, free_y};
  assign ch_ack  = {ack_cr, ack_cb, ack_y};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_luma
      assign ch_en[i]  = 1'b1;
      assign ch_thr[i] = thr_act;
    end else begin : g_chroma
      assign ch_en[i]  = !raw_mode;
      assign ch_thr[i] = thr_half;
    end
    dreq_chan #(.FREE_W(FREE_W)) u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ch_en[i]),
      .thr  (ch_thr[i]),
      .free (ch_free[i]),
      .ack  (ch_ack[i]),
      .req  (ch_req[i])
    );
  end

  assign req_y  = ch_req[0];
  assign req_cb = ch_req[1];
  assign req_cr = ch_req[2];

  dreq_pixdiv #(.PIX_W(PIX_W)) u_pixdiv (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (raw_mode),
    .tick       (pix_tick),
    .frame_start(frame_start),
    .div        (div_fld),
    .pix        (pix_count)
  );

  // R4
  raw_no_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_mode |=> !(req_cb || req_cr));
  // R2
  chroma_below_luma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_act != '0) && !raw_mode && (thr_half > thr_act)) |=> 1'b0);
endmodule

// File: tb/disp_fifo_dma_req_tb.sv
module disp_fifo_dma_req_tb;
  localparam int CLK_P  = 10;
  localparam int FREE_W = 11;
  localparam int PIX_W  = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [31:0]       ctrl_word;
  logic              field2, raw_mode;
  logic [FREE_W-1:0] free_y, free_cb, free_cr;
  logic              ack_y, ack_cb, ack_cr;
  logic              frame_start, pix_tick;
  logic              req_y, req_cb, req_cr;
  logic [PIX_W-1:0]  pix_count;

  int n_vec = 0;
  int n_bad = 0;

  // bench model state
  bit       m_pend [3];
  int       m_pre;
  int       m_pix;

  always #(CLK_P/2) clk = ~clk;

  disp_fifo_dma_req #(.FREE_W(FREE_W), .PIX_W(PIX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .field2(field2),
    .raw_mode(raw_mode), .free_y(free_y), .free_cb(free_cb), .free_cr(free_cr),
    .ack_y(ack_y), .ack_cb(ack_cb), .ack_cr(ack_cr),
    .frame_start(frame_start), .pix_tick(pix_tick),
    .req_y(req_y), .req_cb(req_cb), .req_cr(req_cr), .pix_count(pix_count));

  function automatic int active_thr(input logic [31:0] w, input logic f2);
    return f2 ? int'(w[25:16]) : int'(w[9:0]);   // R3
  endfunction

  function automatic int half_up(input int t);
    return t / 2 + t % 2;                          // R2
  endfunction

  function automatic int tick_len(input logic [3:0] d);
    return (d == 4'd0) ? 16 : int'(d);             // R7
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // Apply one clock with the inputs as set; predict, then compare after the edge.
  task automatic step(input string tag);
    int  t, th;
    int  frees [3];
    bit  acks  [3];
    bit  en    [3];
    bit  exp_r [3];
    frees = '{int'(free_y), int'(free_cb), int'(free_cr)};
    acks  = '{ack_y, ack_cb, ack_cr};
    t = active_thr(ctrl_word, field2);
    en = '{1'b1, !raw_mode, !raw_mode};            // R4
    for (int i = 0; i < 3; i++) begin
      th = (i == 0) ? t : half_up(t);
      exp_r[i] = en[i] && (t != 0) && (frees[i] >= th) && !m_pend[i];  // R1 R6
      if (exp_r[i]) m_pend[i] = 1'b1;
      else if (acks[i]) m_pend[i] = 1'b0;          // R5
    end
    if (frame_start) begin                         // R8
      m_pre = 0; m_pix = 0;
    end else if (raw_mode && pix_tick) begin
      if (m_pre + 1 >= tick_len(ctrl_word[15:12])) begin
        m_pre = 0; m_pix++;
      end else m_pre++;
    end
    @(posedge clk);
    #1;
    chk({tag, "/R1"}, "req_y",  int'(req_y),  int'(exp_r[0]));
    chk({tag, "/R2"}, "req_cb", int'(req_cb), int'(exp_r[1]));
    chk({tag, "/R2"}, "req_cr", int'(req_cr), int'(exp_r[2]));
    chk({tag, "/R7"}, "pix_count", int'(pix_count), m_pix % (1 << PIX_W));
  endtask

  task automatic idle_inputs();
    ack_y = 0; ack_cb = 0; ack_cr = 0; frame_start = 0; pix_tick = 0;
  endtask

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed;
    int burst_left;
    seed = 32'h5eed_0017;
    void'($urandom(seed));
    rst_n = 0; ctrl_word = 32'h0000_1000; field2 = 0; raw_mode = 0;
    free_y = 0; free_cb = 0; free_cr = 0; idle_inputs();
    for (int i = 0; i < 3; i++) m_pend[i] = 0;
    m_pre = 0; m_pix = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("reset", "req_y", int'(req_y), 0);
    chk("reset", "req_cb", int'(req_cb), 0);
    chk("reset", "pix_count", int'(pix_count), 0);
    rst_n = 1;

    // R6: zero threshold with plenty of room never requests
    ctrl_word = 32'h0000_0000; free_y = 11'd1000; free_cb = 11'd1000; free_cr = 11'd1000;
    repeat (4) step("R6");

    // R1/R2 boundary: T=7 -> chroma 4; exactly at threshold requests, one below does not
    ctrl_word = 32'h0000_0007; free_y = 11'd6; free_cb = 11'd3; free_cr = 11'd4;
    step("R2edge");
    free_y = 11'd7;
    step("R1edge");
    // R5: held room, no ack -> no repeat
    repeat (3) step("R5");
    ack_y = 1; ack_cb = 1; ack_cr = 1;
    step("R5ack");
    idle_inputs();
    step("R5re");

    // R3: field 2 threshold large, field 1 small
    ctrl_word = 32'h0200_0002; field2 = 1; free_y = 11'd100;
    ack_y = 1; ack_cb = 1; ack_cr = 1; step("R3"); idle_inputs();
    repeat (2) step("R3");
    field2 = 0; ack_y = 1; step("R3"); idle_inputs(); step("R3");

    // R9: reserved bits set alone must not enable anything
    ctrl_word = 32'hFC00_0C00; ack_y = 1; ack_cb = 1; ack_cr = 1;
    step("R9"); idle_inputs(); repeat (2) step("R9");

    // R7: divisor code 0 means 16 ticks in raw mode
    raw_mode = 1; ctrl_word = 32'h0000_0000; frame_start = 1; step("R8");
    frame_start = 0; pix_tick = 1;
    repeat (33) step("R7div16");
    // R8: frame start beats a tick
    frame_start = 1; step("R8"); frame_start = 0;
    pix_tick = 0;

    // random phase
    burst_left = 0;
    for (int n = 0; n < 6000; n++) begin
      if (burst_left == 0) begin
        burst_left = 20 + int'($urandom_range(0, 60));
        raw_mode = $urandom_range(0, 3) == 0;
        ctrl_word = $urandom;                      // includes reserved bits (R9)
        if ($urandom_range(0, 7) == 0) ctrl_word[9:0] = 10'd0;
        if ($urandom_range(0, 3) == 0) ctrl_word[9:0] = 10'($urandom_range(1, 20));
        if ($urandom_range(0, 3) == 0) ctrl_word[25:16] = 10'($urandom_range(1, 20));
      end
      burst_left--;
      field2      = $urandom_range(0, 7) == 0 ? !field2 : field2;
      free_y      = 11'($urandom_range(0, 1100));
      free_cb     = 11'($urandom_range(0, 600));
      free_cr     = 11'($urandom_range(0, 600));
      ack_y       = $urandom_range(0, 3) == 0;
      ack_cb      = $urandom_range(0, 3) == 0;
      ack_cr      = $urandom_range(0, 3) == 0;
      frame_start = $urandom_range(0, 199) == 0;
      pix_tick    = $urandom_range(0, 1) == 1;
      step("rand");
    end
    idle_inputs();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule